// File: doc/BRIEF.md
# Region-Based Memory Access Guard

This block screens each memory access issued by a processor core against a bank of programmable address windows. Every window has an inclusive lower and upper bound, separate read, write and execute grants, an execute-never flag, an enable flag and a translate-enable flag. For each access it decides whether the access is allowed and reports which window matched. A denied access raises a one-cycle fault pulse together with a reason code.

Windows are loaded through a simple write port that selects one window and one of its three fields per write. An access request consists of a valid strobe, a 32-bit address and a two-bit access kind. The verdict comes from a register and appears in the cycle after the strobe. The translate-enable bit of the winning window is reported with the verdict so that a downstream stage can decide whether to remap the address. This block does not remap anything itself.

Top module: `region_guard`

## Requirements
- R1: The block holds NREG (default 16) windows. A configuration write with `cfg_we` high stores `cfg_wdata` into window `cfg_idx`. `cfg_sel` selects the field: 0 loads the lower bound, 1 loads the upper bound, 2 loads the attributes. The attribute bits are 0 read grant, 1 write grant, 2 execute grant, 3 execute-never, 4 enable and 5 translate-enable.
- R2: An enabled window matches an address when lower <= address <= upper, with both bounds inclusive and the comparison made on unsigned 32-bit values.
- R3: A window whose enable bit is clear never matches, whatever its bounds.
- R4: When several enabled windows match, the window with the lowest index wins, and `rsp_region` reports that index.
- R5: An access that matches no window is denied with reason 1. In that case `rsp_hit` is 0, `rsp_region` is 0 and `rsp_translate` is 0.
- R6: An instruction fetch (kind 2) that wins a window with execute-never set is denied with reason 3, even if the window grants execute.
- R7: For other accesses, kind 0 (read) needs the read grant, kind 1 (write) needs the write grant and kind 2 (fetch) needs the execute grant. Kind 3 is checked as a read. A missing grant denies the access with reason 2. An allowed access reports reason 0.
- R8: A request sampled with `req_valid` high at a clock edge produces `rsp_valid` high for exactly the following cycle. `fault_pulse` is high exactly when that response is a denial.
- R9: `rsp_translate` reports the translate-enable bit of the winning window.
- R10: A request presented in the same cycle as a configuration write is judged against the old window contents. The first request after that write is judged against the new contents.
- R11: Synchronous active-low reset clears every window's attributes, which leaves every window disabled with translate off, and drives all response outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Window index for the write |
| cfg_sel | input | 2 | Field select: 0 lower, 1 upper, 2 attributes |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_allow | output | 1 | Access permitted |
| rsp_hit | output | 1 | Some window matched |
| rsp_region | output | 4 | Index of the winning window |
| rsp_translate | output | 1 | Translate-enable bit of the winning window |
| fault_pulse | output | 1 | High for a denied response |
| fault_reason | output | 2 | 0 none, 1 no window, 2 missing grant, 3 execute-never |

## Verification
The bench hits addresses exactly at each bound, one below the lower bound and one above the upper bound. A design that uses strict or signed comparisons would misjudge these edges, including the window that ends at the top of the address space. Overlapping windows, in which the lower-numbered window denies and the higher-numbered one allows, expose a design that picks the wrong priority. Disabling that window afterwards exposes a design that still matches a disabled window. A fetch into a window that grants execute but has execute-never set catches a design that checks only the execute grant. A write that lands in the same cycle as a request, and a reset in the middle of the run, catch designs that use new contents too early or that leave windows enabled after reset.

// File: rtl/rg_pkg.sv
// Shared encodings for the region guard: access kinds, fault reasons,
// attribute layout and configuration field selectors.
package rg_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        WHY_NONE     = 2'd0,
        WHY_NOREGION = 2'd1,
        WHY_PERM     = 2'd2,
        WHY_XN       = 2'd3
    } why_t;

    // Attribute word: bit0 read, bit1 write, bit2 exec, bit3 xn, bit4 enable, bit5 translate
    typedef struct packed {
        logic translate;
        logic enable;
        logic xn;
        logic px;
        logic pw;
        logic pr;
    } rattr_t;

    localparam int ATTR_W = 6;

    localparam logic [1:0] SEL_LO   = 2'd0;
    localparam logic [1:0] SEL_HI   = 2'd1;
    localparam logic [1:0] SEL_ATTR = 2'd2;

endpackage

// File: rtl/rg_region_file.sv
// Window storage. Holds lower bound, upper bound and attributes per window.
// Assumes ADDR_W >= ATTR_W. Writes to an index at or beyond NREG are dropped.
// Reset clears attributes only; bounds are don't-care while disabled.
module rg_region_file
    import rg_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] lo_q   [NREG],
    output logic [ADDR_W-1:0] hi_q   [NREG],
    output rattr_t            attr_q [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_win
        logic sel_this;
        assign sel_this = cfg_we && (cfg_idx == IDX_W'(g));

        // Load bounds on a matching write; bounds need no reset.
        always_ff @(posedge clk) begin
            if (sel_this && cfg_sel == SEL_LO) lo_q[g] <= cfg_wdata;
            if (sel_this && cfg_sel == SEL_HI) hi_q[g] <= cfg_wdata;
        end

        // Load attributes on a matching write; reset disables the window.
        always_ff @(posedge clk) begin
            if (!rst_n)
                attr_q[g] <= '0;
            else if (sel_this && cfg_sel == SEL_ATTR)
                attr_q[g] <= rattr_t'(cfg_wdata[ATTR_W-1:0]);
        end

        // A window is never enabled in the cycle after reset.
        assert_reset_disables_R11: assert property (@(posedge clk)
            !rst_n |=> !attr_q[g].enable);
    end

endmodule

// File: rtl/rg_matcher.sv
// Combinational window matcher. Compares the address with every enabled
// window and selects the lowest-indexed hit. Outputs are zero on no hit.
module rg_matcher
    import rg_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo_q   [NREG],
    input  logic [ADDR_W-1:0] hi_q   [NREG],
    input  rattr_t            attr_q [NREG],
    output logic              hit_any,
    output logic [IDX_W-1:0]  win_idx,
    output rattr_t            win_attr
);

    logic [NREG-1:0] hit_vec;
    logic [NREG-1:0] win_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        // Inclusive unsigned range test gated by enable.
        assign hit_vec[g] = attr_q[g].enable && (addr >= lo_q[g]) && (addr <= hi_q[g]);
    end

    // Isolate the lowest set bit: lowest index has priority.
    assign win_vec = hit_vec & (~hit_vec + NREG'(1));
    assign hit_any = |hit_vec;

    // Encode the one-hot winner into an index and its attributes.
    always_comb begin
        win_idx  = '0;
        win_attr = '0;
        for (int i = 0; i < NREG; i++) begin
            if (win_vec[i]) begin
                win_idx  = win_idx | IDX_W'(i);
                win_attr = win_attr | attr_q[i];
            end
        end
    end

    assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_vec));
    assert_winner_is_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vec & ~hit_vec) == '0);
    assert_winner_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> win_attr.enable);

endmodule

// File: rtl/rg_verdict.sv
// Permission evaluation and response register. Turns the winning window's
// attributes and the access kind into allow/deny and a reason, and registers
// the result for one cycle. Assumes the matcher zeroes attributes on no hit.
module rg_verdict
    import rg_pkg::*;
#(
    parameter int NREG   = 16,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             hit_any,
    input  logic [IDX_W-1:0] win_idx,
    input  rattr_t           win_attr,
    output logic             rsp_valid,
    output logic             rsp_allow,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_region,
    output logic             rsp_translate,
    output logic             fault_pulse,
    output logic [1:0]       fault_reason
);

    acc_kind_t kind;
    logic      grant;
    why_t      why_c;

    assign kind = acc_kind_t'(req_kind);

    // Select the grant bit that this access kind needs.
    always_comb begin
        unique case (kind)
            ACC_WRITE: grant = win_attr.pw;
            ACC_FETCH: grant = win_attr.px;
            default:   grant = win_attr.pr;
        endcase
    end

    // Rank the denial reasons: no window, then execute-never, then grant.
    always_comb begin
        if (!hit_any)
            why_c = WHY_NOREGION;
        else if (kind == ACC_FETCH && win_attr.xn)
            why_c = WHY_XN;
        else if (!grant)
            why_c = WHY_PERM;
        else
            why_c = WHY_NONE;
    end

    // Register the verdict; all fields are zero when no request was sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_allow     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_region    <= '0;
            rsp_translate <= 1'b0;
            fault_pulse   <= 1'b0;
            fault_reason  <= WHY_NONE;
        end else begin
            rsp_valid     <= req_valid;
            rsp_allow     <= req_valid && (why_c == WHY_NONE);
            rsp_hit       <= req_valid && hit_any;
            rsp_region    <= req_valid ? win_idx : '0;
            rsp_translate <= req_valid && win_attr.translate;
            fault_pulse   <= req_valid && (why_c != WHY_NONE);
            fault_reason  <= req_valid ? why_c : WHY_NONE;
        end
    end

    assert_fault_means_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> (rsp_valid && !rsp_allow && fault_reason != WHY_NONE));
    assert_deny_means_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_allow) |-> fault_pulse);
    assert_xn_only_on_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind != ACC_FETCH) |=> fault_reason != WHY_XN);

endmodule

// File: rtl/region_guard.sv
// Region-based memory access guard, top level. Stores NREG address windows,
// judges each access request against them and reports a registered verdict
// one cycle later. Assumes a single clock and synchronous active-low reset.
module region_guard
    import rg_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_region,
    output logic              rsp_translate,
    output logic              fault_pulse,
    output logic [1:0]        fault_reason
);

    logic [ADDR_W-1:0] lo_q   [NREG];
    logic [ADDR_W-1:0] hi_q   [NREG];
    rattr_t            attr_q [NREG];
    logic              hit_any;
    logic [IDX_W-1:0]  win_idx;
    rattr_t            win_attr;

    rg_region_file #(.NREG(NREG), .ADDR_W(ADDR_W)) u_file (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .lo_q(lo_q), .hi_q(hi_q), .attr_q(attr_q)
    );

    rg_matcher #(.NREG(NREG), .ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .addr(req_addr),
        .lo_q(lo_q), .hi_q(hi_q), .attr_q(attr_q),
        .hit_any(hit_any), .win_idx(win_idx), .win_attr(win_attr)
    );

    rg_verdict #(.NREG(NREG)) u_verdict (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind),
        .hit_any(hit_any), .win_idx(win_idx), .win_attr(win_attr),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
        .rsp_region(rsp_region), .rsp_translate(rsp_translate),
        .fault_pulse(fault_pulse), .fault_reason(fault_reason)
    );

    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_stray_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_nomatch_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (!rsp_allow && fault_reason == WHY_NOREGION
                                     && rsp_region == '0 && !rsp_translate));

endmodule

// File: tb/region_guard_bench.sv
// Scoreboard bench: driver tasks predict each verdict from a bench-side
// window model and queue it; a monitor pops and compares on each response.
module region_guard_bench;

    localparam int NREG = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid, rsp_allow, rsp_hit, rsp_translate, fault_pulse;
    logic [3:0]  rsp_region;
    logic [1:0]  fault_reason;

    always #2 clk = ~clk;

    region_guard u_region_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
        .rsp_region(rsp_region), .rsp_translate(rsp_translate),
        .fault_pulse(fault_pulse), .fault_reason(fault_reason)
    );

    typedef struct {
        logic       allow;
        logic       hit;
        logic [3:0] region;
        logic       tr;
        logic [1:0] why;
        string      tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_lo   [NREG];
    logic [31:0] m_hi   [NREG];
    logic [5:0]  m_attr [NREG];
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;

    // Reference verdict computed from the requirements.
    function automatic exp_t predict(logic [31:0] a, logic [1:0] k, string tag);
        exp_t e;
        bit   found = 0;
        int   w = 0;
        logic need;
        e.allow = 0; e.hit = 0; e.region = 0; e.tr = 0; e.why = 2'd1; e.tag = tag;
        for (int i = 0; i < NREG; i++)
            if (!found && m_attr[i][4] && a >= m_lo[i] && a <= m_hi[i]) begin
                found = 1; w = i;
            end
        if (found) begin
            e.hit = 1; e.region = 4'(w); e.tr = m_attr[w][5];
            need = (k == 2'd1) ? m_attr[w][1] : (k == 2'd2) ? m_attr[w][2] : m_attr[w][0];
            if (k == 2'd2 && m_attr[w][3]) e.why = 2'd3;
            else if (!need)                e.why = 2'd2;
            else begin e.why = 2'd0; e.allow = 1; end
        end
        return e;
    endfunction

    function automatic void model_write(logic [3:0] i, logic [1:0] s, logic [31:0] d);
        if (s == 2'd0) m_lo[i] = d;
        else if (s == 2'd1) m_hi[i] = d;
        else if (s == 2'd2) m_attr[i] = d[5:0];
    endfunction

    task automatic note(bit ok, string tag, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic wr(logic [3:0] i, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        req_valid = 0; cfg_we = 1; cfg_idx = i; cfg_sel = s; cfg_wdata = d;
        model_write(i, s, d);
    endtask

    task automatic rq(logic [31:0] a, logic [1:0] k, string tag);
        @(negedge clk);
        cfg_we = 0; req_valid = 1; req_addr = a; req_kind = k;
        sb.push_back(predict(a, k, tag));
    endtask

    // Write and request in the same cycle: the verdict uses the old contents.
    task automatic wr_rq(logic [3:0] i, logic [1:0] s, logic [31:0] d,
                         logic [31:0] a, logic [1:0] k, string tag);
        @(negedge clk);
        sb.push_back(predict(a, k, tag));
        model_write(i, s, d);
        cfg_we = 1; cfg_idx = i; cfg_sel = s; cfg_wdata = d;
        req_valid = 1; req_addr = a; req_kind = k;
    endtask

    task automatic idle(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            cfg_we = 0; req_valid = 0;
        end
    endtask

    task automatic set_win(logic [3:0] i, logic [31:0] lo, logic [31:0] hi, logic [5:0] at);
        wr(i, 2'd0, lo);
        wr(i, 2'd1, hi);
        wr(i, 2'd2, {26'd0, at});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cfg_we = 0; req_valid = 0;
        for (int i = 0; i < NREG; i++) m_attr[i] = '0;
        idle(2);
        @(negedge clk);
        rst_n = 1;
    endtask

    // Monitor: compare each response with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    note(0, "R8", "response with no request pending");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    note(rsp_allow == e.allow && rsp_hit == e.hit && rsp_region == e.region
                         && rsp_translate == e.tr && fault_reason == e.why
                         && fault_pulse == !e.allow, e.tag,
                         $sformatf("got allow=%0d hit=%0d reg=%0d tr=%0d why=%0d flt=%0d exp allow=%0d hit=%0d reg=%0d tr=%0d why=%0d flt=%0d",
                                   rsp_allow, rsp_hit, rsp_region, rsp_translate, fault_reason, fault_pulse,
                                   e.allow, e.hit, e.region, e.tr, e.why, !e.allow));
                end
            end else if (fault_pulse) begin
                note(0, "R8", "fault_pulse without rsp_valid (exp 0)");
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not finish (exp completion)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_attr[i] = '0; end
        idle(3);
        @(negedge clk);
        rst_n = 1;
        // R11: outputs quiet straight after reset
        note(!rsp_valid && !rsp_allow && !fault_pulse && fault_reason == 0, "R11",
             $sformatf("after reset valid=%0d allow=%0d fault=%0d (exp 0)", rsp_valid, rsp_allow, fault_pulse));

        rq(32'h0000_1234, 2'd0, "R5");                  // nothing enabled yet

        set_win(4'd2, 32'h0000_1000, 32'h0000_1FFF, 6'h13); // en | W | R
        rq(32'h0000_1000, 2'd0, "R2");                  // lower bound inclusive
        rq(32'h0000_1FFF, 2'd1, "R2");                  // upper bound inclusive
        rq(32'h0000_2000, 2'd0, "R2");                  // one past upper
        rq(32'h0000_0FFF, 2'd0, "R2");                  // one below lower
        rq(32'h0000_1500, 2'd2, "R7");                  // fetch, no exec grant

        set_win(4'd1, 32'h0000_1800, 32'h0000_18FF, 6'h11); // en | R, overlaps window 2
        rq(32'h0000_1800, 2'd1, "R4");                  // window 1 wins, denies write
        rq(32'h0000_18FF, 2'd0, "R4");
        rq(32'h0000_1900, 2'd1, "R4");                  // only window 2

        set_win(4'd15, 32'h8000_0000, 32'hFFFF_FFFF, 6'h1D); // en | xn | X | R (R1 top index)
        rq(32'hFFFF_FFFF, 2'd2, "R6");                  // xn beats exec grant
        rq(32'h8000_0000, 2'd0, "R1");
        rq(32'h8000_0004, 2'd1, "R7");                  // no write grant
        rq(32'h7FFF_FFFF, 2'd0, "R2");                  // unsigned: below window 15

        set_win(4'd3, 32'h0000_3000, 32'h0000_3FFF, 6'h14); // en | X
        rq(32'h0000_3000, 2'd2, "R7");
        rq(32'h0000_3004, 2'd3, "R7");                  // kind 3 checked as read

        wr(4'd1, 2'd2, 32'h0000_0001);                  // window 1 disabled
        rq(32'h0000_1800, 2'd1, "R3");

        wr_rq(4'd2, 2'd2, 32'h0000_0033, 32'h0000_1100, 2'd0, "R10"); // old: translate off
        rq(32'h0000_1100, 2'd0, "R9");                  // new: translate on
        rq(32'h0000_5000, 2'd0, "R9");                  // no hit -> translate 0
        wr_rq(4'd4, 2'd2, 32'h0000_0000, 32'h0000_3100, 2'd2, "R10");

        for (int n = 0; n < 8; n++)                     // back-to-back stream
            rq(32'h0000_1000 + 32'(n) * 32'h0000_0A00, 2'(n % 4), "R8");
        idle(4);
        note(sb.size() == 0, "R8", $sformatf("pending predictions %0d (exp 0)", sb.size()));

        do_reset();
        rq(32'h0000_1100, 2'd0, "R11");                 // windows disabled by reset
        rq(32'hFFFF_FFFF, 2'd0, "R11");
        idle(4);
        note(sb.size() == 0, "R8", $sformatf("pending predictions %0d (exp 0)", sb.size()));

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule